// File: doc/BRIEF.md
# SCL Clock Timing Generator

This block produces the serial clock waveform for a two-wire bus controller acting as bus master. A byte engine enables it and consumes its strobes. The generator counts in prescaled ticks. One tick lasts a power-of-two number of system clocks, and the exponent of that power comes from the timing word. The low phase and the high phase of SCL each last a programmable number of ticks. Each phase field holds its length minus one. One undisturbed SCL period is therefore `(1 << exp) * ((hi + 1) + (lo + 1))` system clocks.

The block drives SCL only by pulling it low (`scl_drive_low`). It reads the real line back on `scl_in`. The engine can keep the low phase going by holding `hold_low`. A target on the bus can also stretch the clock by keeping the line low after release. The high-phase count only advances while the line is sensed high. Registered one-cycle strobes mark the falling edge, the rising edge and a mid-high sample point. When `run` is low, SCL is released and every strobe stays quiet.

Top module: `scl_pacer`

## Requirements
- R1: After reset, and for as long as `run` is low, `scl_drive_low`, `scl_rise_stb`, `scl_fall_stb` and `scl_sample_stb` are all 0.
- R2: Without stretching, the rise strobe appears `(1 << exp) * (lo + 1)` cycles after the fall strobe. `scl_drive_low` is 1 throughout that interval.
- R3: Without stretching, the fall strobe appears `(1 << exp) * (hi + 1)` cycles after the rise strobe.
- R4: Timing word layout: `hi` is in bits [19:16], `lo` is in bits [15:12] and `exp` is in bits [3:0]. Bits [31:20] and [11:4] have no effect on the waveform.
- R5: The sample strobe appears `(1 << exp) * ((hi >> 1) + 1)` cycles after the rise strobe, while SCL is released.
- R6: The clock after `run` is first sampled high, `scl_drive_low` and the fall strobe are both 1. A full low phase follows.
- R7: One cycle after `run` is sampled low, SCL is released and no strobe fires. Re-enabling restarts with a fresh, full-length low phase.
- R8: While `hold_low` is 1 at the end of the low count, SCL stays driven low. The rise strobe appears one cycle after `hold_low` is sampled 0. A full high phase follows.
- R9: Each cycle in which `scl_in` is sensed low during the high phase adds one cycle to the high phase and delays the sample strobe by the same amount. SCL stays released meanwhile.
- R10: With `PHASE_W = 3`, the phase fields are bits [18:16] and [14:12]. Bits 19 and 15 are ignored.
- R11: Rise and fall strobes are single-cycle and never coincide. `scl_drive_low` is 1 in the fall-strobe cycle and 0 in the rise-strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enable from the byte engine |
| hold_low | input | 1 | Engine request to keep SCL low past the low count |
| cfg_word | input | 32 | Packed timing word |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise_stb | output | 1 | One-cycle strobe at SCL release |
| scl_fall_stb | output | 1 | One-cycle strobe at SCL pull-down |
| scl_sample_stb | output | 1 | One-cycle strobe at mid-high sample point |

## Verification
The bench builds two instances. The first uses the default 4-bit phase fields. With it, phase lengths up to 16 ticks and exponents up to 5 are measured, along with junk in the uninterpreted bits, engine hold and line stretching. The second uses `PHASE_W = 3`, which shows that bits 19 and 15 drop out of the decode. Small exponents keep every period short enough to measure edge-to-edge, cycle by cycle.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;
  // Field positions inside the timing word (the decode depends on them)
  localparam int HI_LSB  = 16;
  localparam int LO_LSB  = 12;
  localparam int EXP_LSB = 0;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOW  = 2'd1,
    SQ_HOLD = 2'd2,
    SQ_HIGH = 2'd3
  } seq_state_t;
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode #(
  parameter int CFG_W   = 32,
  parameter int PHASE_W = 4,
  parameter int EXP_W   = 4
) (
  input  logic [CFG_W-1:0]   cfg_word,
  output logic [PHASE_W-1:0] hi_len,
  output logic [PHASE_W-1:0] lo_len,
  output logic [EXP_W-1:0]   exp_sel
);
  import scl_pacer_pkg::*;

  logic unused_cfg;

  assign hi_len     = cfg_word[HI_LSB +: PHASE_W];
  assign lo_len     = cfg_word[LO_LSB +: PHASE_W];
  assign exp_sel    = cfg_word[EXP_LSB +: EXP_W];
  assign unused_cfg = ^cfg_word;
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // limit = 2^exp - 1, built without a wide shift of a constant 1
  assign limit = ~({CNT_W{1'b1}} << exp_sel);
  assign tick  = !clr && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               tick,
  input  logic               hold_low,
  input  logic               scl_in,
  input  logic [PHASE_W-1:0] hi_len,
  input  logic [PHASE_W-1:0] lo_len,
  output logic               pre_clr,
  output logic               drive_low,
  output logic               rise_stb,
  output logic               fall_stb,
  output logic               smp_stb
);
  import scl_pacer_pkg::*;

  seq_state_t         state;
  logic [PHASE_W-1:0] cnt;
  logic [PHASE_W-1:0] hi_mid;

  assign hi_mid  = hi_len >> 1;
  // Prescaler restarts whenever a phase start is not yet anchored
  assign pre_clr = !run || (state == SQ_IDLE) || (state == SQ_HOLD) ||
                   ((state == SQ_HIGH) && !scl_in);

  always_ff @(posedge clk) begin
    rise_stb <= 1'b0;
    fall_stb <= 1'b0;
    smp_stb  <= 1'b0;
    if (rst || !run) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      drive_low <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          state     <= SQ_LOW;
          cnt       <= '0;
          drive_low <= 1'b1;
          fall_stb  <= 1'b1;
        end
        SQ_LOW: begin
          if (tick) begin
            if (cnt == lo_len) begin
              cnt <= '0;
              if (hold_low) begin
                state <= SQ_HOLD;
              end else begin
                state     <= SQ_HIGH;
                drive_low <= 1'b0;
                rise_stb  <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        SQ_HOLD: begin
          if (!hold_low) begin
            state     <= SQ_HIGH;
            drive_low <= 1'b0;
            rise_stb  <= 1'b1;
          end
        end
        SQ_HIGH: begin
          if (tick) begin
            if (cnt == hi_mid) smp_stb <= 1'b1;
            if (cnt == hi_len) begin
              state     <= SQ_LOW;
              cnt       <= '0;
              drive_low <= 1'b1;
              fall_stb  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
  parameter int CFG_W   = 32,
  parameter int PHASE_W = 4,
  parameter int EXP_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             hold_low,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             scl_rise_stb,
  output logic             scl_fall_stb,
  output logic             scl_sample_stb
);
  logic [PHASE_W-1:0] hi_len;
  logic [PHASE_W-1:0] lo_len;
  logic [EXP_W-1:0]   exp_sel;
  logic               tick;
  logic               pre_clr;

  scl_cfg_decode #(.CFG_W(CFG_W), .PHASE_W(PHASE_W), .EXP_W(EXP_W)) u_dec (
    .cfg_word (cfg_word),
    .hi_len   (hi_len),
    .lo_len   (lo_len),
    .exp_sel  (exp_sel)
  );

  scl_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .clr     (pre_clr),
    .exp_sel (exp_sel),
    .tick    (tick)
  );

  scl_phase_seq #(.PHASE_W(PHASE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .tick      (tick),
    .hold_low  (hold_low),
    .scl_in    (scl_in),
    .hi_len    (hi_len),
    .lo_len    (lo_len),
    .pre_clr   (pre_clr),
    .drive_low (scl_drive_low),
    .rise_stb  (scl_rise_stb),
    .fall_stb  (scl_fall_stb),
    .smp_stb   (scl_sample_stb)
  );
endmodule

// File: rtl/scl_pacer_chk.sv
module scl_pacer_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic hold_low,
  input logic drive_low,
  input logic rise,
  input logic fall,
  input logic smp
);
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!drive_low && !rise && !fall && !smp)); // R7

  AST_START_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |=> (drive_low && fall)); // R6

  AST_HOLD_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (run && hold_low && drive_low) |=> drive_low); // R8

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R11

  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall); // R11

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise, fall})); // R11

  AST_EDGE_LEVELS: assert property (@(posedge clk) disable iff (rst)
    (rise |-> !drive_low) and (fall |-> drive_low)); // R11

  AST_SAMPLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    smp |-> (drive_low == fall)); // R5
endmodule

bind scl_pacer scl_pacer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .hold_low  (hold_low),
  .drive_low (scl_drive_low),
  .rise      (scl_rise_stb),
  .fall      (scl_fall_stb),
  .smp       (scl_sample_stb)
);

// File: tb/scl_pacer_tb.sv
module scl_pacer_tb;
  localparam int LIMIT = 3000;

  typedef struct packed {
    logic [31:0] cfg;
    logic [15:0] lo_n;
    logic [15:0] hi_n;
    logic [15:0] smp_n;
  } vec_t;

  // cfg, expected low, high, sample offset (cycles)
  localparam vec_t VECS [7] = '{
    '{32'h0000_0000, 16'd1,  16'd1,  16'd1 },
    '{32'h0003_5000, 16'd6,  16'd4,  16'd2 },
    '{32'h0002_1001, 16'd4,  16'd6,  16'd4 },
    '{32'h000F_F002, 16'd64, 16'd64, 16'd32},
    '{32'h0007_0003, 16'd8,  16'd64, 16'd32},
    '{32'hABC1_95A0, 16'd10, 16'd2,  16'd1 },
    '{32'h0000_1005, 16'd64, 16'd32, 16'd32}
  };

  logic clk = 1'b0;
  logic rst, run, hold, ext_low, run3, use3;
  logic [31:0] cfg, cfg3;
  logic drv, rise, fall, smp, scl;
  logic drv3, rise3, fall3, smp3, scl3;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign scl  = !(drv | ext_low);
  assign scl3 = !drv3;

  scl_pacer u_dut (
    .clk(clk), .rst(rst), .run(run), .hold_low(hold), .cfg_word(cfg),
    .scl_in(scl), .scl_drive_low(drv), .scl_rise_stb(rise),
    .scl_fall_stb(fall), .scl_sample_stb(smp)
  );

  scl_pacer #(.PHASE_W(3)) u_dut3 (
    .clk(clk), .rst(rst), .run(run3), .hold_low(1'b0), .cfg_word(cfg3),
    .scl_in(scl3), .scl_drive_low(drv3), .scl_rise_stb(rise3),
    .scl_fall_stb(fall3), .scl_sample_stb(smp3)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic s_drv();  return use3 ? drv3  : drv;  endfunction
  function automatic logic s_rise(); return use3 ? rise3 : rise; endfunction
  function automatic logic s_fall(); return use3 ? fall3 : fall; endfunction
  function automatic logic s_smp();  return use3 ? smp3  : smp;  endfunction

  task automatic set_run(input logic v);
    if (use3) run3 = v; else run = v;
  endtask

  task automatic wait_rise(output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!s_rise() && c < LIMIT);
  endtask

  task automatic wait_fall(output int c, output int sc);
    c = 0; sc = -1;
    do begin
      @(negedge clk); c++;
      if (s_smp() && sc < 0) sc = c;
    end while (!s_fall() && c < LIMIT);
  endtask

  task automatic measure(input string tag, input int lo_n, input int hi_n, input int smp_n);
    int c, sc;
    @(negedge clk); set_run(1'b1);
    @(negedge clk);
    chk({tag, " R6 first fall strobe"}, int'(s_fall()), 1);
    chk({tag, " R6 drive low at start"}, int'(s_drv()), 1);
    wait_rise(c);
    chk({tag, " R2 low phase"}, c, lo_n);
    chk({tag, " R11 released at rise"}, int'(s_drv()), 0);
    wait_fall(c, sc);
    chk({tag, " R3 high phase"}, c, hi_n);
    chk({tag, " R5 sample offset"}, sc, smp_n);
    wait_rise(c);
    chk({tag, " R2 second low phase"}, c, lo_n);
    set_run(1'b0);
    @(negedge clk);
    chk({tag, " R7 released after disable"}, int'(s_drv() | s_rise() | s_fall() | s_smp()), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c, sc, quiet, stayed;
    rst = 1'b1; run = 1'b0; hold = 1'b0; ext_low = 1'b0;
    run3 = 1'b0; use3 = 1'b0; cfg = '0; cfg3 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs in reset", int'({drv, rise, fall, smp}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs idle after reset", int'({drv, rise, fall, smp}), 0);

    // Table walk: R2 R3 R5 R6 R7, vector 5 carries junk bits (R4)
    for (int i = 0; i < 7; i++) begin
      cfg = VECS[i].cfg;
      measure($sformatf("vec%0d", i), int'(VECS[i].lo_n), int'(VECS[i].hi_n), int'(VECS[i].smp_n));
      repeat (2) @(negedge clk);
    end

    // R4: all uninterpreted bits set; hi=2 lo=3 exp=1
    cfg = 32'hFFF2_3FF1;
    measure("R4 junk bits", 8, 6, 4);

    // R7: disable in mid low phase, then a fresh full restart
    cfg = 32'h0003_5000;
    @(negedge clk); run = 1'b1;
    repeat (3) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R7 drive released after disable", int'(drv), 0);
    quiet = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      quiet += int'(drv | rise | fall | smp);
    end
    chk("R7 quiet while disabled", quiet, 0);
    measure("R7 restart", 6, 4, 2);

    // R8: engine hold stretches the low phase; hi=3 lo=2 exp=0
    cfg = 32'h0003_2000;
    hold = 1'b1;
    @(negedge clk); run = 1'b1;
    @(negedge clk);
    chk("R8 fall at start with hold", int'(fall), 1);
    stayed = 0; quiet = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      stayed += int'(drv);
      quiet  += int'(rise);
    end
    chk("R8 drive held low", stayed, 10);
    chk("R8 no rise while held", quiet, 0);
    hold = 1'b0;
    @(negedge clk);
    chk("R8 rise one cycle after release", int'(rise), 1);
    wait_fall(c, sc);
    chk("R8 full high after hold", c, 4);
    run = 1'b0;
    repeat (2) @(negedge clk);

    // R9: line held low by a target for 5 cycles after release
    @(negedge clk); run = 1'b1;
    wait_rise(c);
    ext_low = 1'b1;
    c = 0; sc = -1; stayed = 0;
    do begin
      @(negedge clk); c++;
      if (ext_low) stayed += int'(drv);
      if (c == 5) ext_low = 1'b0;
      if (smp && sc < 0) sc = c;
    end while (!fall && c < LIMIT);
    chk("R9 stretched high phase", c, 9);
    chk("R9 delayed sample", sc, 7);
    chk("R9 released during stretch", stayed, 0);
    run = 1'b0;
    repeat (2) @(negedge clk);

    // R10: 3-bit variant ignores bits 19 and 15 (hi=2 lo=3 exp=0)
    use3 = 1'b1;
    cfg3 = 32'h000A_B000;
    measure("R10 narrow fields", 4, 3, 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule